// File: doc/BRIEF.md
# Lockout One-Shot Delay Element

This block delays a rising edge by a programmable number of ticks and refuses new edges while it is counting. An idle element that sees its input rise latches the delay setting, asserts `busy` and counts down. Rising edges during that count are thrown away and leave no trace. When the count ends, `busy` drops and the output goes high. The output then stays high for at least one more delay length, and after that for as long as the input stays high.

Because of this lockout, a burst of input pulses shorter than the delay collapses into a single forwarded event, so the element works as a debouncer. Elements can be chained to get longer delays. An element whose output is fed back through an inverter to its own input runs as a free-running oscillator with a period of about twice the delay. ANDing the input with the inverted output gives a pulse about one delay long on each rising edge.

The tick rate is set by `CYCLES_PER_TICK`. With a 20 Hz tick, the 1 to 200 tick range covers 0.05 s to 10 s.

Top module: `lockout_delay`

## Requirements
- R1: While `rst_n` is low at a clock edge, the element returns to idle, with `sig_out` low and `busy` low after that edge.
- R2: A rising edge of `sig_in` sampled at a clock edge while idle asserts `busy` from that edge for exactly N ticks. N is the clamped delay setting.
- R3: The 8-bit `delay_ticks` value is clamped: 0 acts as 1 and values above `MAX_TICKS` (200) act as 200.
- R4: `sig_out` rises exactly N ticks after the edge that sampled the trigger, in the same cycle that `busy` falls. `busy` and `sig_out` are never high together.
- R5: Rising edges of `sig_in` while `busy` is high are ignored and not remembered: they neither restart the count nor cause a second output event.
- R6: Once high, `sig_out` stays high for at least N ticks. After that it stays high while `sig_in` is high, and it falls at the first edge that samples `sig_in` low.
- R7: After `sig_out` falls, the first rising edge of `sig_in` is accepted as a new trigger.
- R8: With `sig_in` driven by the inverse of `sig_out` (and one tick per clock), the output rises every 2N+1 clock cycles.
- R9: Any burst of input pulses that falls entirely inside one hold window produces exactly one rising edge of `sig_out`.
- R10: The delay setting is captured when the trigger is accepted. Changing `delay_ticks` during a hold does not change that hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_in | input | 1 | Level input whose rising edge triggers a hold |
| delay_ticks | input | 8 | Requested hold length in ticks (clamped to 1..200) |
| sig_out | output | 1 | Delayed, forwarded signal |
| busy | output | 1 | High during the hold countdown |

## Verification
The bench runs with one tick per clock. A trigger driven at a falling edge is sampled at the next rising edge. `busy` is therefore seen at the next falling edge and holds for N falling-edge samples, and `sig_out` first reads high at the N+1th falling edge after the drive. The fall of `sig_out` is seen one falling edge after `sig_in` is sampled low, once the minimum high time has passed. All outputs are sampled at falling edges, where every register on the path has settled. A cycle model in the bench predicts `sig_out` and `busy` for every cycle, including the random phase. The directed latency, burst, lockout and oscillator-period measurements count falling edges against the figures above.

// File: rtl/lockout_delay_pkg.sv
// Package: shared types for the lockout delay element.
// Assumes: nothing beyond being compiled before the modules that import it.
package lockout_delay_pkg;

    // Phase of the element: waiting, counting down, forwarding.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HOLD = 2'd1,
        PH_FWD  = 2'd2
    } ld_phase_e;

endpackage

// File: rtl/ld_tick_gen.sv
// Module: ld_tick_gen
// Produces a one-cycle tick strobe every CYCLES_PER_TICK clocks.
// Assumes CYCLES_PER_TICK >= 1; with 1 the strobe is high every cycle.
module ld_tick_gen #(
    parameter int CYCLES_PER_TICK = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int DIV_W = (CYCLES_PER_TICK > 1) ? $clog2(CYCLES_PER_TICK) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CYCLES_PER_TICK - 1);

    logic [DIV_W-1:0] div_q;

    // Free-running divider that wraps after the last cycle of a tick.
    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + DIV_W'(1);
    end

    assign tick = (div_q == LAST);

endmodule

// File: rtl/ld_edge_det.sv
// Module: ld_edge_det
// Flags a rising edge of a synchronous level input for one cycle.
// Assumes the input is already synchronous to clk.
module ld_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    // Remember last cycle's level; reset treats the input as previously low.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;

endmodule

// File: rtl/ld_hold_core.sv
// Module: ld_hold_core
// Phase machine and countdown of the lockout delay element.
// Assumes `rise` is a one-cycle edge strobe and `tick` a one-cycle strobe.
// The delay setting is clamped and captured on trigger acceptance.
module ld_hold_core
    import lockout_delay_pkg::*;
#(
    parameter int CFG_W     = 8,
    parameter int MAX_TICKS = 200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rise,
    input  logic             level,
    input  logic [CFG_W-1:0] cfg,
    output logic             out,
    output logic             busy
);
    localparam int CNT_W = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_TICKS);

    ld_phase_e        phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] len_clamped;

    // Clamp the requested length into 1..MAX_TICKS.
    always_comb begin
        if (cfg == '0)
            len_clamped = CNT_ONE;
        else if (int'(cfg) > MAX_TICKS)
            len_clamped = CNT_MAX;
        else
            len_clamped = CNT_W'(cfg);
    end

    // Phase sequencing, countdown and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            out     <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (rise) begin
                        len_q   <= len_clamped;
                        cnt_q   <= len_clamped;
                        phase_q <= PH_HOLD;
                    end
                end
                PH_HOLD: begin
                    if (tick) begin
                        if (cnt_q == CNT_ONE) begin
                            phase_q <= PH_FWD;
                            out     <= 1'b1;
                            cnt_q   <= len_q;
                        end else begin
                            cnt_q <= cnt_q - CNT_ONE;
                        end
                    end
                end
                PH_FWD: begin
                    if (cnt_q > CNT_ONE) begin
                        if (tick) cnt_q <= cnt_q - CNT_ONE;
                    end else if (!level) begin
                        out     <= 1'b0;
                        phase_q <= PH_IDLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign busy = (phase_q == PH_HOLD);

    // R3: an accepted trigger loads a length inside 1..MAX_TICKS.
    p_load_clamped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && rise) |=> (cnt_q >= CNT_ONE && cnt_q <= CNT_MAX));

    // R5: a hold in progress only counts down, whatever the input does.
    p_no_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && tick && cnt_q > CNT_ONE) |=> (cnt_q == $past(cnt_q) - CNT_ONE));

    // R10: the captured length is stable while holding.
    p_len_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_HOLD && $past(phase_q) == PH_HOLD) |-> $stable(len_q));

endmodule

// File: rtl/lockout_delay.sv
// Module: lockout_delay (top)
// Lockout one-shot delay element: a rising input edge seen while idle starts
// a hold of N ticks; edges during the hold are dropped; afterwards the output
// goes high for at least N ticks and then follows the input low.
// Assumes sig_in is synchronous to clk and rst_n is synchronous, active low.
module lockout_delay #(
    parameter int CFG_W           = 8,
    parameter int MAX_TICKS       = 200,
    parameter int CYCLES_PER_TICK = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sig_in,
    input  logic [CFG_W-1:0] delay_ticks,
    output logic             sig_out,
    output logic             busy
);
    logic tick;
    logic rise;

    ld_tick_gen #(
        .CYCLES_PER_TICK(CYCLES_PER_TICK)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    ld_edge_det u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .level(sig_in),
        .rise (rise)
    );

    ld_hold_core #(
        .CFG_W    (CFG_W),
        .MAX_TICKS(MAX_TICKS)
    ) u_core (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .rise (rise),
        .level(sig_in),
        .cfg  (delay_ticks),
        .out  (sig_out),
        .busy (busy)
    );

    // R1: a reset edge leaves both outputs low.
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!sig_out && !busy));

    // R4: output and busy are never high together.
    p_busy_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sig_out);

    // R4: the output only rises as a hold finishes.
    p_rise_ends_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sig_out) |-> ($past(busy) && !busy));

    // R6: outside reset, the output only falls after the input was sampled low.
    p_fall_on_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sig_out) && $past(rst_n)) |-> !$past(sig_in));

endmodule

// File: tb/sim_lockout_delay.sv
module sim_lockout_delay;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       drv = 1'b0;
    logic       osc = 1'b0;
    logic [7:0] cfg = 8'd5;
    logic       sig_in;
    logic       sig_out;
    logic       busy;

    int n_vec  = 0;
    int n_fail = 0;
    bit cmp_en = 1'b0;

    assign sig_in = osc ? ~sig_out : drv;

    always #5 clk = ~clk;

    lockout_delay u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .sig_in     (sig_in),
        .delay_ticks(cfg),
        .sig_out    (sig_out),
        .busy       (busy)
    );

    function automatic int clamp_len(input int c);
        if (c < 1)   return 1;
        if (c > 200) return 200;
        return c;
    endfunction

    // Reference cycle model built from the requirements.
    int m_ph = 0, m_cnt = 0, m_len = 0;
    bit m_prev = 0, m_out = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_out = 0; m_prev = 0; m_cnt = 0;
        end else begin
            bit r;
            r = sig_in && !m_prev;
            m_prev = sig_in;
            case (m_ph)
                0: if (r) begin m_len = clamp_len(int'(cfg)); m_cnt = m_len; m_ph = 1; end
                1: if (m_cnt == 1) begin m_ph = 2; m_out = 1; m_cnt = m_len; end
                   else m_cnt--;
                default: if (m_cnt > 1) m_cnt--;
                         else if (!sig_in) begin m_out = 0; m_ph = 0; end
            endcase
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model (R2 R4 R6 busy/output timing).
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R2 model busy", int'(busy), int'(m_ph == 1));
            check("R4 model out", int'(sig_out), int'(m_out));
        end
    end

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    endtask

    initial begin
        #(10 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // Drive trigger, return falling edges until out high and busy samples.
    task automatic trigger(input int c, output int lat, output int bcnt);
        cfg = 8'(c); drv = 1'b1; lat = 0; bcnt = 0;
        while (lat < 1000) begin
            @(negedge clk); lat++;
            if (busy) bcnt++;
            if (sig_out) break;
        end
    endtask

    task automatic settle;
        drv = 1'b0; osc = 1'b0;
        repeat (450) @(negedge clk);
    endtask

    initial begin
        int lat, bc, rises, t1, t2, hi;
        bit pv;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset out", int'(sig_out), 0);
        check("R1 reset busy", int'(busy), 0);
        rst_n = 1'b1; cmp_en = 1'b1;
        @(negedge clk);

        // R2 R4: basic delay of 5
        trigger(5, lat, bc);
        check("R4 latency N=5", lat, 6);
        check("R2 busy length N=5", bc, 5);
        settle();

        // R3: clamp low and high
        trigger(0, lat, bc);
        check("R3 clamp zero", lat, 2);
        settle();
        trigger(250, lat, bc);
        check("R3 clamp high", lat, 201);
        check("R3 busy clamp high", bc, 200);
        settle();

        // R5 R9: burst inside hold, input ends low; R6 minimum high time
        cfg = 8'd20; rises = 0; hi = 0; pv = 0;
        for (int i = 0; i < 70; i++) begin
            drv = (i < 12) ? i[0] == 1'b0 : 1'b0;
            @(negedge clk);
            if (sig_out && !pv) rises++;
            if (sig_out) hi++;
            pv = sig_out;
        end
        check("R9 burst single event", rises, 1);
        check("R5 no remembered edge", rises, 1);
        check("R6 minimum high", hi, 20);
        settle();

        // R6: held input keeps output high, falls one edge after low
        trigger(4, lat, bc);
        repeat (30) @(negedge clk);
        check("R6 held high", int'(sig_out), 1);
        drv = 1'b0;
        @(negedge clk);
        check("R6 fall after low", int'(sig_out), 0);

        // R7: immediate retrigger once idle
        drv = 1'b1;
        @(negedge clk);
        check("R7 retrigger busy", int'(busy), 1);
        settle();

        // R10: change setting during hold
        trigger(7, lat, bc);
        check("R10 baseline", lat, 8);
        settle();
        cfg = 8'd7; drv = 1'b1;
        @(negedge clk); cfg = 8'd60;
        lat = 1;
        while (!sig_out && lat < 500) begin @(negedge clk); lat++; end
        check("R10 latched setting", lat, 8);
        settle();

        // R8: inverter loop period
        cfg = 8'd6; osc = 1'b1; pv = 0; t1 = -1; t2 = -1;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (sig_out && !pv) begin
                if (t1 < 0) t1 = i; else if (t2 < 0) t2 = i;
            end
            pv = sig_out;
        end
        check("R8 oscillator period", t2 - t1, 13);
        settle();

        // R1: reset during hold
        trigger(30, lat, bc);
        drv = 1'b1; cfg = 8'd30;
        settle();
        drv = 1'b1; @(negedge clk); @(negedge clk);
        rst_n = 1'b0; @(negedge clk);
        check("R1 reset mid-hold busy", int'(busy), 0);
        rst_n = 1'b1; drv = 1'b0; @(negedge clk);

        // Random phase, checked every cycle against the model
        for (int i = 0; i < 6000; i++) begin
            if ($urandom % 6 == 0) drv = ~drv;
            if ($urandom % 50 == 0) cfg = 8'($urandom % 24);
            if ($urandom % 997 == 0) rst_n = 1'b0; else rst_n = 1'b1;
            @(negedge clk);
        end
        report();
    end
endmodule